// File: doc/BRIEF.md
# Reset-Addressed Field Delay Memory

This block is one channel of line or field storage for a video-style stream. A write port and a read port each run on their own clock, and the two clocks need not be related. Each port has a free-running address counter with an active-low enable and an active-low synchronous clear. The block has no full or empty flag and never compares the two pointers. The delay between a word going in and the same word coming out is set only by when the two clears are applied.

If both clears are pulsed together and both ports then run without a break, every word comes back exactly `DEPTH` read cycles after it was written. Shorter delays are made in one of two ways: pulse both clears every `n` cycles, or pulse the read clear `n` cycles after the write clear. In both cases `n` must be at least 16 and at most `DEPTH`. The read port registers its data and raises a registered output-enable flag. A chip-level pad can use this flag to tri-state the bus.

Top module: `field_delay_mem`

## Requirements
- R1: On a rising `wr_clk` with `wr_rst_n` high and `wr_en_n` low, `wr_data` is stored at the current write address, and the write address then advances by one.
- R2: On a rising `wr_clk` with both `wr_en_n` and `wr_rst_n` high, no word is stored and the write address keeps its value.
- R3: On a rising `wr_clk` with `wr_rst_n` low, the write address returns to 0 and nothing is stored, whatever the level of `wr_en_n`. The next enabled write goes to address 0.
- R4: On a rising `rd_clk` with `rd_rst_n` high and `rd_en_n` low, `rd_data` takes the word at the current read address, `rd_oe` becomes 1, and the read address advances by one.
- R5: On a rising `rd_clk` with both `rd_en_n` and `rd_rst_n` high, `rd_oe` becomes 0, `rd_data` keeps its value and the read address holds.
- R6: On a rising `rd_clk` with `rd_rst_n` low, the read address returns to 0 while `rd_data` and `rd_oe` keep their values. The next enabled read returns address 0.
- R7: Both address counters wrap from `DEPTH-1` to 0 without any indication. A write past the last address overwrites address 0 onward.
- R8: If both clears are applied on the same cycle and both ports then run every cycle, each read returns the word written `DEPTH` cycles earlier.
- R9: If both clears are repeated every `n` cycles (16 <= n <= DEPTH), each read returns the word written `n` cycles earlier.
- R10: If the read clear follows the write clear by `n` cycles (16 <= n <= DEPTH) and both ports then run every cycle, each read returns the word written `n` cycles earlier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Write port clock |
| wr_en_n | input | 1 | Write enable, active low |
| wr_rst_n | input | 1 | Write address clear, active low, synchronous |
| wr_data | input | WIDTH | Word to store |
| rd_clk | input | 1 | Read port clock |
| rd_en_n | input | 1 | Read enable, active low |
| rd_rst_n | input | 1 | Read address clear, active low, synchronous |
| rd_data | output | WIDTH | Registered read word |
| rd_oe | output | 1 | Registered output-enable qualifier for `rd_data` |

## Verification
On every clock, the assertions check the per-edge rules of each counter: advance, hold and clear on each port. They also check the output-enable flag and that read data stays still on cycles that do not read. The delay relations are only visible to the bench's scenarios, because they depend on the pair of counters over hundreds of cycles. These cover the full-depth line delay, periodic clears, offset clears, wrap-around overwrite, and words written or skipped around a clear.

// File: rtl/fdm_pkg.sv
package fdm_pkg;

  // Action a port counter takes on its clock edge.
  typedef enum logic [1:0] {
    ACT_IDLE  = 2'd0,
    ACT_STEP  = 2'd1,
    ACT_CLEAR = 2'd2
  } ctr_act_e;

  // Clear wins over enable; enable and clear have no ordering restriction.
  function automatic ctr_act_e fdm_decode(input logic en_n, input logic rst_n);
    if (!rst_n)     return ACT_CLEAR;
    else if (!en_n) return ACT_STEP;
    return ACT_IDLE;
  endfunction

endpackage

// File: rtl/fdm_addr_ctr.sv
module fdm_addr_ctr
  import fdm_pkg::*;
#(
  parameter int DEPTH = 256,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          en_n,
  input  logic          rst_n,
  output logic [AW-1:0] addr,
  output ctr_act_e      act,
  output logic          armed
);

  // Power-of-two depth: the natural carry-out drop is the wrap.
  function automatic logic [AW-1:0] step_addr(input logic [AW-1:0] a);
    return a + 1'b1;
  endfunction

  logic [AW-1:0] addr_q;
  logic          armed_q;

  assign act   = fdm_decode(en_n, rst_n);
  assign addr  = addr_q;
  assign armed = armed_q;

  always_ff @(posedge clk) begin
    unique case (act)
      ACT_CLEAR: addr_q <= '0;
      ACT_STEP:  addr_q <= step_addr(addr_q);
      default:   addr_q <= addr_q;
    endcase
  end

  // Becomes 1 at the first clear; the counter value is meaningful after that.
  always_ff @(posedge clk) begin
    if (!rst_n) armed_q <= 1'b1;
  end

  AST_CTR_STEP: assert property (@(posedge clk) disable iff (!armed_q)
    (act == ACT_STEP) |=> (addr_q - $past(addr_q)) == AW'(1)); // R1
  // Same rule on the read instance and for the wrap past DEPTH-1. // R4 R7
  AST_CTR_HOLD: assert property (@(posedge clk) disable iff (!armed_q)
    (act == ACT_IDLE) |=> $stable(addr_q)); // R2
  // Read instance holds likewise. // R5
  AST_CTR_CLEAR: assert property (@(posedge clk) disable iff (!armed_q)
    (act == ACT_CLEAR) |=> (addr_q == '0)); // R3
  // Read instance clears likewise. // R6

endmodule

// File: rtl/fdm_store.sv
module fdm_store #(
  parameter int WIDTH = 8,
  parameter int DEPTH = 256,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic             wclk,
  input  logic             we,
  input  logic [AW-1:0]    waddr,
  input  logic [WIDTH-1:0] wdata,
  input  logic             rclk,
  input  logic             re,
  input  logic [AW-1:0]    raddr,
  input  logic             chk_en,
  output logic [WIDTH-1:0] rdata
);

  logic [WIDTH-1:0] mem [DEPTH];

  always_ff @(posedge wclk) begin
    if (we) mem[waddr] <= wdata;
  end

  always_ff @(posedge rclk) begin
    if (re) rdata <= mem[raddr];
  end

  AST_DATA_KEEP: assert property (@(posedge rclk) disable iff (!chk_en)
    !re |=> $stable(rdata)); // R5

endmodule

// File: rtl/fdm_out_stage.sv
module fdm_out_stage
  import fdm_pkg::*;
(
  input  logic     clk,
  input  ctr_act_e act,
  input  logic     chk_en,
  output logic     oe
);

  always_ff @(posedge clk) begin
    unique case (act)
      ACT_STEP:  oe <= 1'b1;
      ACT_IDLE:  oe <= 1'b0;
      default:   oe <= oe;
    endcase
  end

  AST_OE_ON: assert property (@(posedge clk) disable iff (!chk_en)
    (act == ACT_STEP) |=> oe); // R4
  AST_OE_OFF: assert property (@(posedge clk) disable iff (!chk_en)
    (act == ACT_IDLE) |=> !oe); // R5
  AST_OE_KEEP: assert property (@(posedge clk) disable iff (!chk_en)
    (act == ACT_CLEAR) |=> $stable(oe)); // R6

endmodule

// File: rtl/field_delay_mem.sv
module field_delay_mem
  import fdm_pkg::*;
#(
  parameter int WIDTH = 8,
  parameter int DEPTH = 256
) (
  input  logic             wr_clk,
  input  logic             wr_en_n,
  input  logic             wr_rst_n,
  input  logic [WIDTH-1:0] wr_data,
  input  logic             rd_clk,
  input  logic             rd_en_n,
  input  logic             rd_rst_n,
  output logic [WIDTH-1:0] rd_data,
  output logic             rd_oe
);

  localparam int AW = $clog2(DEPTH);

  // Named internal events, brought out for the assertions.
  logic [AW-1:0] wr_addr, rd_addr;
  ctr_act_e      wr_act, rd_act;
  logic          wr_armed, rd_armed;
  logic          wr_fire, rd_fire;

  assign wr_fire = (wr_act == ACT_STEP);
  assign rd_fire = (rd_act == ACT_STEP);

  fdm_addr_ctr #(.DEPTH(DEPTH)) u_wr_ctr (
    .clk(wr_clk), .en_n(wr_en_n), .rst_n(wr_rst_n),
    .addr(wr_addr), .act(wr_act), .armed(wr_armed)
  );

  fdm_addr_ctr #(.DEPTH(DEPTH)) u_rd_ctr (
    .clk(rd_clk), .en_n(rd_en_n), .rst_n(rd_rst_n),
    .addr(rd_addr), .act(rd_act), .armed(rd_armed)
  );

  fdm_store #(.WIDTH(WIDTH), .DEPTH(DEPTH)) u_store (
    .wclk(wr_clk), .we(wr_fire), .waddr(wr_addr), .wdata(wr_data),
    .rclk(rd_clk), .re(rd_fire), .raddr(rd_addr), .chk_en(rd_armed),
    .rdata(rd_data)
  );

  fdm_out_stage u_out (
    .clk(rd_clk), .act(rd_act), .chk_en(rd_armed), .oe(rd_oe)
  );

  AST_WR_CLEAR_NO_STORE: assert property (@(posedge wr_clk) disable iff (!wr_armed)
    !wr_rst_n |-> !wr_fire); // R3

endmodule

// File: tb/field_delay_mem_tb.sv
module field_delay_mem_tb;
  localparam int W = 8;
  localparam int D = 256;

  logic         wclk = 1'b0, rclk = 1'b0;
  logic         wen_n = 1'b1, wrst_n = 1'b1, ren_n = 1'b1, rrst_n = 1'b1;
  logic [W-1:0] wdat = '0;
  wire  [W-1:0] rdat;
  wire          roe;
  int n_chk = 0, n_bad = 0;

  field_delay_mem #(.WIDTH(W), .DEPTH(D)) u_dut (
    .wr_clk(wclk), .wr_en_n(wen_n), .wr_rst_n(wrst_n), .wr_data(wdat),
    .rd_clk(rclk), .rd_en_n(ren_n), .rd_rst_n(rrst_n),
    .rd_data(rdat), .rd_oe(roe)
  );

  // 100 MHz write clock; read clock at the same rate, edges 3 ns earlier.
  always #5 wclk = ~wclk;
  initial begin
    #2;
    forever begin rclk = 1'b1; #5 rclk = 1'b0; #5; end
  end

  function automatic logic [W-1:0] pat(input int k);
    return W'(k * 3 + (k / 256) * 101 + 17);
  endfunction

  // Drive at a write-clock falling edge; the read edge then the write edge consume it;
  // outputs are sampled at the following falling edge.
  task automatic step(input logic we_n, input logic wr_n, input logic [W-1:0] d,
                      input logic re_n, input logic rr_n);
    wen_n = we_n; wrst_n = wr_n; wdat = d; ren_n = re_n; rrst_n = rr_n;
    @(negedge wclk);
  endtask

  task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic t_reset_state;
    step(1, 0, 0, 1, 0);
    step(1, 1, 0, 1, 1);
    chk("R5 oe low after idle read edge", W'(roe), W'(0));
  endtask

  task automatic t_basic;  // R1 R4
    step(1, 0, 0, 1, 0);
    for (int i = 0; i < 20; i++) step(0, 1, W'(8'hA0 + i), 1, 1);
    step(1, 1, 0, 1, 0);
    for (int i = 0; i < 20; i++) begin
      step(1, 1, 0, 0, 1);
      chk("R4 read data", rdat, W'(8'hA0 + i));
      chk("R4 oe high", W'(roe), W'(1));
    end
  endtask

  task automatic t_write_hold;  // R2
    step(1, 0, 0, 1, 1);
    for (int i = 0; i < 5; i++) step(0, 1, W'(8'h10 + i), 1, 1);
    for (int i = 0; i < 3; i++) step(1, 1, W'(8'hEE), 1, 1);
    for (int i = 5; i < 10; i++) step(0, 1, W'(8'h10 + i), 1, 1);
    step(1, 1, 0, 1, 0);
    for (int i = 0; i < 10; i++) begin
      step(1, 1, 0, 0, 1);
      chk("R2 disabled writes leave no gap", rdat, W'(8'h10 + i));
    end
  endtask

  task automatic t_read_idle;  // R5
    step(1, 1, 0, 1, 0);
    for (int i = 0; i < 3; i++) begin
      step(1, 1, 0, 0, 1);
      chk("R5 pre-idle read", rdat, W'(8'h10 + i));
    end
    for (int i = 0; i < 2; i++) begin
      step(1, 1, 0, 1, 1);
      chk("R5 oe low while idle", W'(roe), W'(0));
      chk("R5 data holds while idle", rdat, W'(8'h12));
    end
    step(1, 1, 0, 0, 1);
    chk("R5 read resumes at held address", rdat, W'(8'h13));
    chk("R5 oe back high", W'(roe), W'(1));
  endtask

  task automatic t_clear_with_enable;  // R3 R6
    step(1, 0, 0, 1, 1);
    for (int i = 0; i < 8; i++) step(0, 1, W'(8'hA0 + i), 1, 1);
    step(0, 0, W'(8'h55), 1, 1);
    step(0, 1, W'(8'h77), 1, 1);
    step(1, 1, 0, 1, 0);
    step(1, 1, 0, 0, 1);
    chk("R3 write after clear lands at 0", rdat, W'(8'h77));
    step(1, 1, 0, 0, 1);
    chk("R3 clear edge stored nothing", rdat, W'(8'hA1));
    step(1, 1, 0, 0, 0);
    chk("R6 data holds on read clear", rdat, W'(8'hA1));
    chk("R6 oe holds on read clear", W'(roe), W'(1));
    step(1, 1, 0, 0, 1);
    chk("R6 next read returns address 0", rdat, W'(8'h77));
  endtask

  task automatic t_wrap;  // R7
    step(1, 0, 0, 1, 1);
    for (int i = 0; i < D + 3; i++) step(0, 1, pat(i), 1, 1);
    step(1, 1, 0, 1, 0);
    for (int i = 0; i < 4; i++) begin
      step(1, 1, 0, 0, 1);
      chk("R7 wrap overwrite", rdat, (i < 3) ? pat(D + i) : pat(3));
    end
  endtask

  task automatic t_line_delay;  // R8
    step(0, 0, 0, 0, 0);
    for (int k = 0; k < 2 * D + 16; k++) begin
      step(0, 1, pat(k + 300), 0, 1);
      if (k >= D) chk("R8 full-depth delay", rdat, pat(k - D + 300));
    end
  endtask

  task automatic t_periodic;  // R9
    for (int k = 0; k < 100; k++) begin
      if (k % 20 == 0) step(0, 0, 0, 0, 0);
      else begin
        step(0, 1, pat(k + 700), 0, 1);
        if (k > 20) chk("R9 periodic clear delay", rdat, pat(k - 20 + 700));
      end
    end
  endtask

  task automatic t_offset;  // R10
    for (int k = 0; k < 100; k++) begin
      if (k == 0)       step(0, 0, 0, 1, 1);
      else if (k < 24)  step(0, 1, pat(k + 900), 1, 1);
      else if (k == 24) step(0, 1, pat(k + 900), 1, 0);
      else begin
        step(0, 1, pat(k + 900), 0, 1);
        chk("R10 offset clear delay", rdat, pat(k - 24 + 900));
      end
    end
  endtask

  task automatic summary;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
  endtask

  initial begin
    #2_000_000;
    n_chk++; n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    @(negedge wclk);
    t_reset_state();
    t_basic();
    t_write_hold();
    t_read_idle();
    t_clear_with_enable();
    t_wrap();
    t_line_delay();
    t_periodic();
    t_offset();
    summary();
    $finish;
  end
endmodule